// File: doc/BRIEF.md
# Indexed Bit and Rotate Unit

This block carries out the four-byte indexed bit group of an 8-bit processor core. That group is a prefix, a 0xCB escape, a signed displacement, and a trailing sub-opcode. The sequencer fetches those bytes and reads the operand byte from memory. It then presents the index register value, the displacement, the sub-opcode, the operand and the current flags in one cycle with `in_valid` high.

One clock later the unit returns several outputs. It gives the effective address and the modified byte. It gives the new flags and whether that byte must be stored back to memory. It gives whether the byte must also be copied into a general register, and which register. It reports the instruction's T-state count and whether the encoding is undocumented. The sequencer uses these to schedule the remaining bus cycles. The trailing sub-opcode is an operand read and not an opcode fetch, so the sequencer counts refresh steps only for the two opcode fetches.

Top module: `ibr_unit`

## Requirements
- R1: `tgt_addr` equals `index_val` plus the sign-extended `disp`, truncated to 16 bits. The sum wraps at both ends of the address space.
- R2: When sub-opcode bits 7:6 are 00, bits 5:3 select one shift operation: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL, 7 SRL. RL and RR shift the incoming carry (flag bit 0) into the result. SLL inserts a 1 at bit 0. The bit shifted out becomes the new carry.
- R3: The flags byte is laid out as S=7, Z=6, H=4, P=2, N=1, C=0, with bits 5 and 3 undocumented. After a shift operation, S, Z, bit 5 and bit 3 follow the result. P is set for an even number of ones in the result. H and N are cleared.
- R4: When bits 7:6 are 01, the unit tests operand bit n, where n is bits 5:3. Z and P are set when that bit is 0. S is set only when n is 7 and the bit is 1. H is set and N is cleared. C, bit 5 and bit 3 keep their incoming values. The result equals the operand.
- R5: When bits 7:6 are 10, the unit clears operand bit n. When they are 11, it sets operand bit n. In both cases the flags leave unchanged.
- R6: `mem_we` is high for every operation except the bit test.
- R7: `t_cycles` is 20 for a bit test and 23 for every other operation.
- R8: When bits 2:0 are not 6, `reg_copy` is high and `reg_sel` gives the register as 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A. This applies to bit tests too, which copy the unchanged operand. When bits 2:0 are 6, `reg_copy` is low.
- R9: `undoc` is high when bits 2:0 are not 6, or when the operation is SLL.
- R10: All outputs update on the clock edge that samples `in_valid` high and then hold. `out_valid` is a one-cycle pulse on that edge and is low out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| index_val | input | 16 | Index register value |
| disp | input | 8 | Signed displacement byte |
| subop | input | 8 | Trailing sub-opcode |
| operand | input | 8 | Byte read from the target address |
| flags_in | input | 8 | Current flags |
| out_valid | output | 1 | Result pulse, one cycle after `in_valid` |
| tgt_addr | output | 16 | Effective address |
| result | output | 8 | Byte after the operation |
| flags_out | output | 8 | New flags |
| mem_we | output | 1 | Store `result` to `tgt_addr` |
| reg_copy | output | 1 | Also copy `result` to a register |
| reg_sel | output | 3 | Register selected for the copy |
| t_cycles | output | 5 | T-states taken by the instruction |
| undoc | output | 1 | Encoding is undocumented |

## Verification
The hardest outcome to reach is the set of undocumented side paths. These are a bit test that still copies the unchanged operand into a register, and SLL in its documented register field, which must still report undocumented. Such cases sit among 256 sub-opcodes where most rows look alike. The stimulus therefore sweeps every sub-opcode once with carry clear and once with carry set, using an operand whose bits differ at both edges. It adds displacements that wrap the address at 0x0000 and 0xFFFF, then runs a seeded random phase with back-to-back and gapped issues.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  // flag byte bit positions
  localparam int FLG_C = 0;
  localparam int FLG_N = 1;
  localparam int FLG_P = 2;
  localparam int FLG_X = 3;
  localparam int FLG_H = 4;
  localparam int FLG_Y = 5;
  localparam int FLG_Z = 6;
  localparam int FLG_S = 7;

  // sub-opcode bits 7:6
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  // sub-opcode bits 5:3 inside the shift group
  typedef enum logic [2:0] {
    SH_RLC = 3'd0,
    SH_RRC = 3'd1,
    SH_RL  = 3'd2,
    SH_RR  = 3'd3,
    SH_SLA = 3'd4,
    SH_SRA = 3'd5,
    SH_SLL = 3'd6,
    SH_SRL = 3'd7
  } shift_e;

  // register field value that means memory only
  localparam logic [2:0] REG_NONE = 3'd6;

endpackage

// File: rtl/ibr_addr.sv
module ibr_addr #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] offs,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] offs_ext;

  assign offs_ext = {{EXT_W{offs[DISP_W-1]}}, offs};
  assign addr     = base + offs_ext;
endmodule

// File: rtl/ibr_ctl.sv
module ibr_ctl
  import ibr_pkg::*;
#(
  parameter int T_FETCH   = 4,
  parameter int T_READ    = 3,
  parameter int T_SUB_GAP = 2,
  parameter int T_OPD_GAP = 1,
  parameter int T_WRITE   = 3,
  parameter int CYC_W     = 5
) (
  input  logic [7:0]       subop,
  output grp_e             grp,
  output logic [2:0]       sel,
  output logic             wb,
  output logic             copy,
  output logic [2:0]       reg_sel,
  output logic [CYC_W-1:0] cycles,
  output logic             undoc
);
  // two opcode fetches, displacement read, sub-opcode read + gap, operand read + gap
  localparam int T_TEST   = 2*T_FETCH + T_READ + (T_READ + T_SUB_GAP) + (T_READ + T_OPD_GAP);
  localparam int T_MODIFY = T_TEST + T_WRITE;

  always_comb begin
    grp     = grp_e'(subop[7:6]);
    sel     = subop[5:3];
    reg_sel = subop[2:0];
    copy    = (reg_sel != REG_NONE);
    wb      = (grp != GRP_TEST);
    cycles  = wb ? CYC_W'(T_MODIFY) : CYC_W'(T_TEST);
    undoc   = copy || ((grp == GRP_SHIFT) && (shift_e'(sel) == SH_SLL));
  end
endmodule

// File: rtl/ibr_alu.sv
module ibr_alu
  import ibr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  grp_e              grp,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] opd,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] res,
  output logic [7:0]        flags_out
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] mask;
  logic              sh_c;
  logic              hit;
  logic              cin;

  // one-hot bit mask from the bit-number field
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (32'(sel) == i);
  end

  assign cin = flags_in[FLG_C];
  assign hit = |(opd & mask);

  always_comb begin
    res       = opd;
    flags_out = flags_in;
    sh_c      = 1'b0;
    unique case (grp)
      GRP_SHIFT: begin
        unique case (shift_e'(sel))
          SH_RLC: begin res = {opd[MSB-1:0], opd[MSB]}; sh_c = opd[MSB]; end
          SH_RRC: begin res = {opd[0], opd[MSB:1]};     sh_c = opd[0];   end
          SH_RL:  begin res = {opd[MSB-1:0], cin};      sh_c = opd[MSB]; end
          SH_RR:  begin res = {cin, opd[MSB:1]};        sh_c = opd[0];   end
          SH_SLA: begin res = {opd[MSB-1:0], 1'b0};     sh_c = opd[MSB]; end
          SH_SRA: begin res = {opd[MSB], opd[MSB:1]};   sh_c = opd[0];   end
          SH_SLL: begin res = {opd[MSB-1:0], 1'b1};     sh_c = opd[MSB]; end
          SH_SRL: begin res = {1'b0, opd[MSB:1]};       sh_c = opd[0];   end
        endcase
        flags_out[FLG_S] = res[MSB];
        flags_out[FLG_Z] = (res == '0);
        flags_out[FLG_Y] = res[5];
        flags_out[FLG_H] = 1'b0;
        flags_out[FLG_X] = res[3];
        flags_out[FLG_P] = ~^res;
        flags_out[FLG_N] = 1'b0;
        flags_out[FLG_C] = sh_c;
      end
      GRP_TEST: begin
        flags_out[FLG_S] = hit && (32'(sel) == MSB);
        flags_out[FLG_Z] = !hit;
        flags_out[FLG_H] = 1'b1;
        flags_out[FLG_P] = !hit;
        flags_out[FLG_N] = 1'b0;
      end
      GRP_CLR: res = opd & ~mask;
      GRP_SET: res = opd | mask;
    endcase
  end
endmodule

// File: rtl/ibr_unit.sv
module ibr_unit
  import ibr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int T_FETCH   = 4,
  parameter int T_READ    = 3,
  parameter int T_SUB_GAP = 2,
  parameter int T_OPD_GAP = 1,
  parameter int T_WRITE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [DATA_W-1:0] disp,
  input  logic [7:0]        subop,
  input  logic [DATA_W-1:0] operand,
  input  logic [7:0]        flags_in,
  output logic              out_valid,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags_out,
  output logic              mem_we,
  output logic              reg_copy,
  output logic [2:0]        reg_sel,
  output logic [4:0]        t_cycles,
  output logic              undoc
);
  localparam int T_TEST   = 2*T_FETCH + T_READ + (T_READ + T_SUB_GAP) + (T_READ + T_OPD_GAP);
  localparam int T_MODIFY = T_TEST + T_WRITE;
  localparam int CYC_W    = 5;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // combinational datapath
  grp_e              c_grp;
  logic [2:0]        c_sel;
  logic              c_wb;
  logic              c_copy;
  logic [2:0]        c_rsel;
  logic [CYC_W-1:0]  c_cyc;
  logic              c_undoc;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_res;
  logic [7:0]        c_flags;

  ibr_addr #(.ADDR_W(ADDR_W), .DISP_W(DATA_W)) u_addr (
    .base (index_val),
    .offs (disp),
    .addr (c_addr)
  );

  ibr_ctl #(
    .T_FETCH(T_FETCH), .T_READ(T_READ), .T_SUB_GAP(T_SUB_GAP),
    .T_OPD_GAP(T_OPD_GAP), .T_WRITE(T_WRITE), .CYC_W(CYC_W)
  ) u_ctl (
    .subop   (subop),
    .grp     (c_grp),
    .sel     (c_sel),
    .wb      (c_wb),
    .copy    (c_copy),
    .reg_sel (c_rsel),
    .cycles  (c_cyc),
    .undoc   (c_undoc)
  );

  ibr_alu #(.DATA_W(DATA_W)) u_alu (
    .grp       (c_grp),
    .sel       (c_sel),
    .opd       (operand),
    .flags_in  (flags_in),
    .res       (c_res),
    .flags_out (c_flags)
  );

  // output register: next-state and storage
  logic              q_valid,  d_valid;
  logic [ADDR_W-1:0] q_addr,   d_addr;
  logic [DATA_W-1:0] q_res,    d_res;
  logic [7:0]        q_flags,  d_flags;
  logic              q_we,     d_we;
  logic              q_copy,   d_copy;
  logic [2:0]        q_rsel,   d_rsel;
  logic [CYC_W-1:0]  q_cyc,    d_cyc;
  logic              q_undoc,  d_undoc;
  grp_e              q_grp,    d_grp;

  always_comb begin
    d_valid = in_valid;
    d_addr  = q_addr;
    d_res   = q_res;
    d_flags = q_flags;
    d_we    = q_we;
    d_copy  = q_copy;
    d_rsel  = q_rsel;
    d_cyc   = q_cyc;
    d_undoc = q_undoc;
    d_grp   = q_grp;
    if (in_valid) begin
      d_addr  = c_addr;
      d_res   = c_res;
      d_flags = c_flags;
      d_we    = c_wb;
      d_copy  = c_copy;
      d_rsel  = c_rsel;
      d_cyc   = c_cyc;
      d_undoc = c_undoc;
      d_grp   = c_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_res   <= '0;
      q_flags <= '0;
      q_we    <= 1'b0;
      q_copy  <= 1'b0;
      q_rsel  <= '0;
      q_cyc   <= '0;
      q_undoc <= 1'b0;
      q_grp   <= GRP_SHIFT;
    end else begin
      q_valid <= d_valid;
      q_addr  <= d_addr;
      q_res   <= d_res;
      q_flags <= d_flags;
      q_we    <= d_we;
      q_copy  <= d_copy;
      q_rsel  <= d_rsel;
      q_cyc   <= d_cyc;
      q_undoc <= d_undoc;
      q_grp   <= d_grp;
    end
  end

  assign out_valid = q_valid;
  assign tgt_addr  = q_addr;
  assign result    = q_res;
  assign flags_out = q_flags;
  assign mem_we    = q_we;
  assign reg_copy  = q_copy;
  assign reg_sel   = q_rsel;
  assign t_cycles  = q_cyc;
  assign undoc     = q_undoc;

  // checks on the registered outputs
  assert_wb_cycles_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (mem_we ? (t_cycles == CYC_W'(T_MODIFY)) : (t_cycles == CYC_W'(T_TEST))));

  assert_test_flags_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && q_grp == GRP_TEST) |-> (flags_out[FLG_H] && !flags_out[FLG_N] && !mem_we));

  assert_shift_hn_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && q_grp == GRP_SHIFT) |-> (!flags_out[FLG_H] && !flags_out[FLG_N]));

  assert_flags_keep_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && (q_grp == GRP_CLR || q_grp == GRP_SET)) |-> (flags_out == $past(flags_in)));

  assert_copy_field_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && reg_copy) |-> (reg_sel != REG_NONE));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/ibr_unit_tb.sv
module ibr_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] index_val;
  logic [7:0]  disp;
  logic [7:0]  subop;
  logic [7:0]  operand;
  logic [7:0]  flags_in;
  logic        out_valid;
  logic [15:0] tgt_addr;
  logic [7:0]  result;
  logic [7:0]  flags_out;
  logic        mem_we;
  logic        reg_copy;
  logic [2:0]  reg_sel;
  logic [4:0]  t_cycles;
  logic        undoc;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  res;
    logic [7:0]  flg;
    logic        we;
    logic        cp;
    logic [2:0]  rs;
    logic [4:0]  cyc;
    logic        ud;
    logic [1:0]  grp;
  } exp_t;

  exp_t sb[$];

  ibr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .index_val(index_val),
    .disp(disp), .subop(subop), .operand(operand), .flags_in(flags_in),
    .out_valid(out_valid), .tgt_addr(tgt_addr), .result(result),
    .flags_out(flags_out), .mem_we(mem_we), .reg_copy(reg_copy),
    .reg_sel(reg_sel), .t_cycles(t_cycles), .undoc(undoc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] ix, input logic [7:0] d,
                                 input logic [7:0] so, input logic [7:0] op,
                                 input logic [7:0] fi);
    exp_t e;
    logic [7:0] m;
    logic       co;
    int         n;
    n     = int'(so[5:3]);
    m     = 8'h01 << n;
    e.addr = ix + {{8{d[7]}}, d};
    e.res  = op;
    e.flg  = fi;
    e.grp  = so[7:6];
    co     = 1'b0;
    case (so[7:6])
      2'b00: begin
        case (so[5:3])
          3'd0: begin e.res = {op[6:0], op[7]}; co = op[7]; end
          3'd1: begin e.res = {op[0], op[7:1]}; co = op[0]; end
          3'd2: begin e.res = {op[6:0], fi[0]}; co = op[7]; end
          3'd3: begin e.res = {fi[0], op[7:1]}; co = op[0]; end
          3'd4: begin e.res = op << 1;           co = op[7]; end
          3'd5: begin e.res = {op[7], op[7:1]}; co = op[0]; end
          3'd6: begin e.res = (op << 1) | 8'h01; co = op[7]; end
          default: begin e.res = op >> 1;        co = op[0]; end
        endcase
        e.flg = {e.res[7], e.res == 8'h00, e.res[5], 1'b0, e.res[3],
                 ($countones(e.res) % 2) == 0, 1'b0, co};
      end
      2'b01: begin
        e.flg[6] = (op[n] == 1'b0);
        e.flg[2] = (op[n] == 1'b0);
        e.flg[7] = (n == 7) && op[7];
        e.flg[4] = 1'b1;
        e.flg[1] = 1'b0;
      end
      2'b10: e.res = op & ~m;
      default: e.res = op | m;
    endcase
    e.we  = (so[7:6] != 2'b01);
    e.cp  = (so[2:0] != 3'd6);
    e.rs  = so[2:0];
    e.cyc = e.we ? 5'd23 : 5'd20;
    e.ud  = e.cp || (so[7:3] == 5'b00110);
    return e;
  endfunction

  task automatic issue(input logic [15:0] ix, input logic [7:0] d, input logic [7:0] so,
                       input logic [7:0] op, input logic [7:0] fi, input int gap);
    @(negedge clk);
    index_val = ix; disp = d; subop = so; operand = op; flags_in = fi;
    in_valid  = 1'b1;
    sb.push_back(model(ix, d, so, op, fi));
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare on each result pulse
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk("R10 unexpected pulse", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        string rt, ft;
        e = sb.pop_front();
        rt = (e.grp == 2'b00) ? "R2 result" : (e.grp == 2'b01) ? "R4 result" : "R5 result";
        ft = (e.grp == 2'b00) ? "R3 flags" : (e.grp == 2'b01) ? "R4 flags" : "R5 flags";
        chk("R1 address", 32'(tgt_addr), 32'(e.addr));
        chk(rt, 32'(result), 32'(e.res));
        chk(ft, 32'(flags_out), 32'(e.flg));
        chk("R6 mem_we", 32'(mem_we), 32'(e.we));
        chk("R7 cycles", 32'(t_cycles), 32'(e.cyc));
        chk("R8 reg_copy", 32'(reg_copy), 32'(e.cp));
        if (e.cp) chk("R8 reg_sel", 32'(reg_sel), 32'(e.rs));
        chk("R9 undoc", 32'(undoc), 32'(e.ud));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    index_val = '0; disp = '0; subop = '0; operand = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", 32'(out_valid), 32'd0);
    chk("R10 reset mem_we", 32'(mem_we), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after reset", 32'(out_valid), 32'd0);

    // R1 wrap cases
    issue(16'h0010, 8'h80, 8'h46, 8'h00, 8'h00, 1);
    issue(16'hFFFF, 8'h01, 8'h46, 8'h00, 8'h00, 1);
    issue(16'h0000, 8'hFF, 8'hC6, 8'h00, 8'h00, 2);
    issue(16'h7FF0, 8'h7F, 8'h86, 8'hFF, 8'h00, 1);
    // R2 SLL documented form and flags, R9
    issue(16'h1234, 8'h05, 8'h36, 8'h80, 8'h00, 1);
    issue(16'h1234, 8'h05, 8'h16, 8'h00, 8'h01, 1);   // RL zero operand, carry in
    issue(16'h1234, 8'h05, 8'h1E, 8'h01, 8'h00, 1);   // RR shifts out 1, Z set
    // R4 bit 7 set gives S, bit test with register copy
    issue(16'h2000, 8'h00, 8'h7E, 8'h80, 8'hA9, 1);
    issue(16'h2000, 8'h00, 8'h40, 8'h5A, 8'h29, 1);

    // full sub-opcode sweep, both carry values
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 256; s++) begin
        issue(16'h4000 + 16'(s), 8'(s * 7), 8'(s), 8'h81, c ? 8'hFF : 8'h00, s % 3);
      end
    end

    // random phase
    for (int i = 0; i < 400; i++) begin
      issue(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            int'($urandom_range(1, 3)));
    end

    repeat (4) @(negedge clk);
    chk("R10 all results seen", 32'(sb.size()), 32'd0);
    chk("R10 idle at end", 32'(out_valid), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule